// File: doc/BRIEF.md
# Video Routing Control Byte I2C Target

This block is a write-only I2C target that holds the single 8-bit control byte of a two-channel video routing controller. It runs on a system clock and samples the SCL and SDA lines through synchronizers. It finds START and STOP conditions and shifts in bytes on SCL rising edges. On SDA it uses only an open-drain pull-down, and only to acknowledge.

The target address is a fixed 4-bit prefix followed by three strap pins. When all three straps are low the bus interface is switched off and the block flags pin-control mode, which tells the surrounding logic to take its routing settings from dedicated pins. A valid transfer is START, address with write, ACK, one data byte, ACK, STOP. Each acknowledged data byte replaces the control register and raises a one-cycle update strobe.

Top module: `vid_route_i2c_ctrl`

## Requirements
- R1: After reset, ctrl_o is 0x00, sda_oe_o is 0 and ctrl_upd_o is 0.
- R2: A first byte equal to {1,1,0,1, strap_i[2:0], 0} (MSB first, last bit 0 = write) is acknowledged: sda_oe_o is 1 across the ninth SCL pulse.
- R3: A first byte with any other address gets no ACK. Later bytes up to the next START get no ACK and leave ctrl_o unchanged.
- R4: The matching address with the last bit 1 (read) gets no ACK.
- R5: When strap_i is 3'b000, pin_mode_o is 1 and the block never drives SDA, not even for address 1101000 with write.
- R6: A data byte received MSB first after an acknowledged address is acknowledged and loaded into ctrl_o when that ACK pulse ends. The fields are: chan_sel_o = bit 7, matrix_en_o = bit 6, gain_o = bits 5..3, fs_prio_o = bit 2, out_state_o = bits 1..0.
- R7: A STOP before the data byte is complete leaves ctrl_o at its previous value.
- R8: Further data bytes in the same transfer are each acknowledged and each overwrites ctrl_o.
- R9: ctrl_upd_o pulses high for exactly one clock per register load, in the cycle ctrl_o takes the new value.
- R10: sda_oe_o is high only inside an acknowledge slot.
- R11: A repeated START discards any partial byte and restarts address matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| strap_i | input | 3 | Low address bits; 000 selects pin-control mode |
| pin_mode_o | output | 1 | Straps select pin-control mode |
| ctrl_o | output | 8 | Control register |
| ctrl_upd_o | output | 1 | One-cycle strobe on each register load |
| chan_sel_o | output | 1 | Channel select field |
| matrix_en_o | output | 1 | Matrix enable field |
| gain_o | output | 3 | Gain code field |
| fs_prio_o | output | 1 | Fast-switch priority field |
| out_state_o | output | 2 | Output state field |

## Verification
The assertions assume that strap_i is static while a transfer is in progress. They also assume SCL stays in each level for several system clocks, so every edge passes the synchronizers as a distinct event and SDA never changes on the same sample as SCL. The stimulus changes the straps only with the bus idle. It moves SDA only a quarter bit after SCL falls and holds each SCL level for eight or more clocks. It releases SDA during every ninth bit so that the block's pull-down is the only driver in the acknowledge slot.

// File: rtl/vr_i2c_pkg.sv
package vr_i2c_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned STRAP_W = 3;
  localparam int unsigned PFX_W   = 4;
  localparam logic [PFX_W-1:0] ADDR_PFX = 4'b1101;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_ACK,
    ST_SKIP
  } bus_state_e;

  typedef struct packed {
    logic       chan_sel;
    logic       matrix_en;
    logic [2:0] gain;
    logic       fs_prio;
    logic [1:0] out_state;
  } ctrl_t;
endpackage

// File: rtl/i2c_bus_sense.sv
module i2c_bus_sense #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic sda_o,
  output logic start_o,
  output logic stop_o
);
  localparam int unsigned CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] scl_sh, sda_sh;

  generate
    for (genvar g = 0; g < CHAIN; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_sh[g] <= 1'b1;
          sda_sh[g] <= 1'b1;
        end else if (g == 0) begin
          scl_sh[g] <= scl_i;
          sda_sh[g] <= sda_i;
        end else begin
          scl_sh[g] <= scl_sh[g-1];
          sda_sh[g] <= sda_sh[g-1];
        end
      end
    end
  endgenerate

  logic scl_now, scl_old, sda_now, sda_old;
  assign scl_now = scl_sh[SYNC_STAGES-1];
  assign scl_old = scl_sh[SYNC_STAGES];
  assign sda_now = sda_sh[SYNC_STAGES-1];
  assign sda_old = sda_sh[SYNC_STAGES];

  assign scl_rise_o = scl_now & ~scl_old;
  assign scl_fall_o = ~scl_now & scl_old;
  assign sda_o      = sda_now;
  // SDA edges while SCL held high
  assign start_o    = scl_now & scl_old & sda_old & ~sda_now;
  assign stop_o     = scl_now & scl_old & ~sda_old & sda_now;
endmodule

// File: rtl/i2c_byte_fsm.sv
module i2c_byte_fsm
  import vr_i2c_pkg::*;
#(
  parameter int unsigned BYTE_W = DATA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_rise_i,
  input  logic               scl_fall_i,
  input  logic               sda_i,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               pin_mode_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               sda_oe_o,
  output logic               byte_vld_o,
  output logic [BYTE_W-1:0]  byte_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  bus_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] shreg_q, byte_q;
  logic              oe_q, ack_data_q, vld_q;
  logic              addr_hit;

  assign addr_hit = (shreg_q == {ADDR_PFX, strap_i, 1'b0});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      shreg_q    <= '0;
      byte_q     <= '0;
      oe_q       <= 1'b0;
      ack_data_q <= 1'b0;
      vld_q      <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (pin_mode_i) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
        cnt_q   <= '0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else if (start_i) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_DATA: begin
            if (scl_rise_i && cnt_q < LAST_BIT) begin
              shreg_q <= {shreg_q[BYTE_W-2:0], sda_i};
              cnt_q   <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == LAST_BIT) begin
              if (state_q == ST_DATA) begin
                oe_q       <= 1'b1;
                ack_data_q <= 1'b1;
                state_q    <= ST_ACK;
              end else if (addr_hit) begin
                oe_q       <= 1'b1;
                ack_data_q <= 1'b0;
                state_q    <= ST_ACK;
              end else begin
                state_q <= ST_SKIP;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              oe_q    <= 1'b0;
              state_q <= ST_DATA;
              cnt_q   <= '0;
              if (ack_data_q) begin
                vld_q  <= 1'b1;
                byte_q <= shreg_q;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o   = oe_q;
  assign byte_vld_o = vld_q;
  assign byte_o     = byte_q;

  p_oe_in_ack_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |-> (state_q == ST_ACK));
  p_pin_silent_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_mode_i |=> !oe_q);
  p_restart_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !stop_i && !pin_mode_i) |=> (state_q == ST_ADDR && cnt_q == '0));
  p_vld_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |=> !vld_q);
  p_skip_silent_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SKIP) |-> !oe_q);
endmodule

// File: rtl/vid_route_i2c_ctrl.sv
module vid_route_i2c_ctrl
  import vr_i2c_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               pin_mode_o,
  output logic [DATA_W-1:0]  ctrl_o,
  output logic               ctrl_upd_o,
  output logic               chan_sel_o,
  output logic               matrix_en_o,
  output logic [2:0]         gain_o,
  output logic               fs_prio_o,
  output logic [1:0]         out_state_o
);
  logic scl_rise, scl_fall, sda_s, start_c, stop_c;
  logic byte_vld;
  logic [DATA_W-1:0] byte_d;
  logic pin_mode;
  ctrl_t ctrl_q;
  logic  upd_q;

  assign pin_mode = (strap_i == '0);

  i2c_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) i_sense (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .sda_o      (sda_s),
    .start_o    (start_c),
    .stop_o     (stop_c)
  );

  i2c_byte_fsm #(.BYTE_W(DATA_W)) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .sda_i      (sda_s),
    .start_i    (start_c),
    .stop_i     (stop_c),
    .pin_mode_i (pin_mode),
    .strap_i    (strap_i),
    .sda_oe_o   (sda_oe_o),
    .byte_vld_o (byte_vld),
    .byte_o     (byte_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= byte_vld;
      if (byte_vld) ctrl_q <= ctrl_t'(byte_d);
    end
  end

  assign pin_mode_o  = pin_mode;
  assign ctrl_o      = ctrl_q;
  assign ctrl_upd_o  = upd_q;
  assign chan_sel_o  = ctrl_q.chan_sel;
  assign matrix_en_o = ctrl_q.matrix_en;
  assign gain_o      = ctrl_q.gain;
  assign fs_prio_o   = ctrl_q.fs_prio;
  assign out_state_o = ctrl_q.out_state;

  p_ctrl_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_vld |=> $stable(ctrl_q));
  p_upd_align_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld |=> (upd_q && ctrl_q == $past(byte_d)));
  p_pin_no_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_mode && $past(pin_mode)) |-> !byte_vld);
endmodule

// File: tb/test_vid_route_i2c_ctrl.sv
`timescale 1ns/1ps
module test_vid_route_i2c_ctrl;
  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_drv = 1'b1;
  logic [2:0] strap = 3'b101;
  logic       sda_oe, pin_mode, ctrl_upd;
  logic [7:0] ctrl;
  logic       chan_sel, matrix_en, fs_prio;
  logic [2:0] gain;
  logic [1:0] out_state;
  wire        sda_line = sda_drv & ~sda_oe;

  int n_chk = 0, n_bad = 0;
  int upd_cnt = 0, upd_wide = 0, oe_stray = 0;
  logic ack_win = 1'b0, upd_prev = 1'b0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  vid_route_i2c_ctrl i_vid_route_i2c_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .strap_i(strap), .pin_mode_o(pin_mode),
    .ctrl_o(ctrl), .ctrl_upd_o(ctrl_upd), .chan_sel_o(chan_sel),
    .matrix_en_o(matrix_en), .gain_o(gain), .fs_prio_o(fs_prio),
    .out_state_o(out_state)
  );

  always @(negedge clk) begin
    if (ctrl_upd) upd_cnt++;
    if (ctrl_upd && upd_prev) upd_wide++;
    upd_prev = ctrl_upd;
    if (sda_oe && !ack_win) oe_stray++;
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; cyc(Q);
    scl = 1'b1; cyc(2*Q);
    sda_drv = 1'b0; cyc(2*Q);
    scl = 1'b0; cyc(Q);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; cyc(Q);
    scl = 1'b1; cyc(2*Q);
    sda_drv = 1'b1; cyc(2*Q);
  endtask

  task automatic send_bit(logic b);
    cyc(Q); sda_drv = b; cyc(Q);
    scl = 1'b1; cyc(2*Q);
    scl = 1'b0;
  endtask

  task automatic send_byte(logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    ack_win = 1'b1;
    cyc(Q); sda_drv = 1'b1; cyc(Q);
    scl = 1'b1; cyc(Q);
    acked = ~sda_line;
    cyc(Q);
    scl = 1'b0;
    cyc(Q);
    ack_win = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 ctrl", ctrl, 0);
    chk("R1 oe", sda_oe, 0);
    chk("R1 upd", ctrl_upd, 0);
  endtask

  task automatic t_write_basic();
    logic a; int u0 = upd_cnt;
    bus_start();
    send_byte(8'hDA, a); chk("R2 addr ack", a, 1);
    send_byte(8'hA5, a); chk("R6 data ack", a, 1);
    chk("R6 ctrl", ctrl, 8'hA5);
    bus_stop();
    chk("R6 chan_sel", chan_sel, 1);
    chk("R6 matrix_en", matrix_en, 0);
    chk("R6 gain", gain, 3'b100);
    chk("R6 fs_prio", fs_prio, 1);
    chk("R6 out_state", out_state, 2'b01);
    chk("R9 one pulse", upd_cnt - u0, 1);
  endtask

  task automatic t_fields_alt();
    logic a;
    bus_start();
    send_byte(8'hDA, a);
    send_byte(8'h5A, a);
    bus_stop();
    chk("R6 alt ctrl", ctrl, 8'h5A);
    chk("R6 alt matrix", matrix_en, 1);
    chk("R6 alt gain", gain, 3'b011);
    chk("R6 alt out", out_state, 2'b10);
  endtask

  task automatic t_mismatch();
    logic a;
    bus_start();
    send_byte(8'hD8, a); chk("R3 no ack addr", a, 0);
    send_byte(8'hFF, a); chk("R3 no ack data", a, 0);
    bus_stop();
    chk("R3 ctrl kept", ctrl, 8'h5A);
  endtask

  task automatic t_read();
    logic a;
    bus_start();
    send_byte(8'hDB, a); chk("R4 read nack", a, 0);
    bus_stop();
    chk("R4 ctrl kept", ctrl, 8'h5A);
  endtask

  task automatic t_strap_change();
    logic a;
    strap = 3'b011; cyc(Q);
    chk("R5 pin mode off", pin_mode, 0);
    bus_start();
    send_byte(8'hD6, a); chk("R2 strap addr ack", a, 1);
    send_byte(8'h3C, a);
    bus_stop();
    chk("R2 strap ctrl", ctrl, 8'h3C);
  endtask

  task automatic t_pin_mode();
    logic a; int u0 = upd_cnt;
    strap = 3'b000; cyc(Q);
    chk("R5 pin mode", pin_mode, 1);
    bus_start();
    send_byte(8'hD0, a); chk("R5 no ack", a, 0);
    send_byte(8'h77, a);
    bus_stop();
    chk("R5 ctrl kept", ctrl, 8'h3C);
    chk("R5 no update", upd_cnt - u0, 0);
    strap = 3'b101; cyc(Q);
  endtask

  task automatic t_abort();
    logic a;
    bus_start();
    send_byte(8'hDA, a);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_stop();
    chk("R7 ctrl kept", ctrl, 8'h3C);
  endtask

  task automatic t_multi();
    logic a; int u0 = upd_cnt;
    bus_start();
    send_byte(8'hDA, a);
    send_byte(8'h11, a); chk("R8 ack 1", a, 1); chk("R8 ctrl 1", ctrl, 8'h11);
    send_byte(8'h22, a); chk("R8 ack 2", a, 1); chk("R8 ctrl 2", ctrl, 8'h22);
    send_byte(8'h33, a); chk("R8 ack 3", a, 1);
    bus_stop();
    chk("R8 ctrl 3", ctrl, 8'h33);
    chk("R9 three pulses", upd_cnt - u0, 3);
  endtask

  task automatic t_rstart();
    logic a;
    bus_start();
    send_byte(8'hDA, a);
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    cyc(Q); sda_drv = 1'b1;
    bus_start();
    send_byte(8'hDA, a); chk("R11 addr after restart", a, 1);
    send_byte(8'hC3, a);
    bus_stop();
    chk("R11 ctrl", ctrl, 8'hC3);
  endtask

  initial begin
    cyc(5);
    rst_n = 1'b1;
    cyc(5);
    t_reset();
    t_write_basic();
    t_fields_alt();
    t_mismatch();
    t_read();
    t_strap_change();
    t_pin_mode();
    t_abort();
    t_multi();
    t_rstart();
    chk("R10 stray drive", oe_stray, 0);
    chk("R9 wide pulse", upd_wide, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule